// File: doc/BRIEF.md
# Chirp Phase Timing Sequencer

This block steps a radar transmitter and receiver through a repeating chirp cycle. The cycle has four phases: a long chirp, a short chirp, a listen window and a guard gap. The length of each phase, counted in clock cycles, comes from configuration inputs that can change at any time. The sequencer samples those inputs only when a new chirp cycle begins, so a cycle in progress keeps the timing it started with.

A decode of the phase register drives two mixer enables: one for the transmit mixer and one for the receive mixer. Because both come only from the phase, they can never be high at the same time. The block also counts finished chirps. When the configured number of chirps per elevation position has been reached, it sends a one-clock step pulse to the beam-steering logic and restarts the count.

A single run input starts and stops the sequence. When run is dropped, the cycle in progress completes through its guard phase before the block returns to idle. A busy output is high whenever the block is not idle.

Top module: `chirp_sequencer`

## Requirements
- R1: While reset is held, and after it is released with run low, `phase` is 0 (idle), and `tx_mix_en`, `rx_mix_en`, `busy` and `elev_step` are all low.
- R2: A chirp cycle goes through the phases long (code 1), short (code 2), listen (code 3) and guard (code 4), in that order. Each phase lasts exactly its configured number of cycles.
- R3: A configured phase length of zero makes that phase last one cycle, so the sequence always advances.
- R4: The four lengths and the chirps-per-elevation count are captured only when a chirp cycle begins, either on leaving idle or on going from guard to long. A change made during a cycle has no effect on that cycle.
- R5: `tx_mix_en` is high exactly when `phase` is long or short.
- R6: `rx_mix_en` is high exactly when `phase` is listen. It is never high in the same cycle as `tx_mix_en`.
- R7: `busy` is high exactly when `phase` is not idle.
- R8: `elev_step` is high for one cycle, in the cycle that follows the end of the guard phase of the Nth chirp counted since the last step or since leaving idle. N is the captured count, and a count of zero acts as one. The chirp count then restarts at zero.
- R9: When `run` is low at the end of a guard phase, the block goes to idle. Dropping `run` earlier does not shorten the cycle in progress. The chirp count restarts from zero while the block is idle.
- R10: When `run` is high in idle, `phase` becomes long in the next cycle. When `run` is high at the end of guard, the next cycle is long with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Start (high) or stop after the current cycle (low) |
| cfg_long_len | input | CNT_W | Long-chirp phase length in cycles |
| cfg_short_len | input | CNT_W | Short-chirp phase length in cycles |
| cfg_listen_len | input | CNT_W | Listen phase length in cycles |
| cfg_guard_len | input | CNT_W | Guard phase length in cycles |
| cfg_chirps_per_elev | input | CPE_W | Chirps per elevation step |
| phase | output | 3 | Current phase code: 0 idle, 1 long, 2 short, 3 listen, 4 guard |
| tx_mix_en | output | 1 | Transmit mixer enable |
| rx_mix_en | output | 1 | Receive mixer enable |
| busy | output | 1 | High when not idle |
| elev_step | output | 1 | One-cycle elevation step pulse |

## Verification
Inputs that the phase register samples at a clock edge show up on `phase`, `tx_mix_en`, `rx_mix_en` and `busy` one cycle later. Those three enables are decoded from the phase with no further register. The elevation pulse passes through one register after the last guard cycle, so it appears in the first cycle of the following long or idle phase. The bench drives inputs on the falling edge. At each rising edge it advances a cycle model written from the requirements, and it compares every output with that model at the next falling edge. Each check therefore lands exactly in the cycle where the requirement puts the result.

// File: rtl/chirp_seq_pkg.sv
// Package: shared phase encoding for the chirp sequencer.
// Assumes: the phase codes are visible at the top ports, so their values are fixed.
package chirp_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LONG   = 3'd1,
        PH_SHORT  = 3'd2,
        PH_LISTEN = 3'd3,
        PH_GUARD  = 3'd4
    } phase_e;
endpackage

// File: rtl/chirp_phase_fsm.sv
// Module: chirp_phase_fsm
// Steps idle -> long -> short -> listen -> guard and times each phase
// against lengths captured at the start of every chirp cycle.
// Assumes: synchronous active-low reset; a length of zero is timed as one cycle.
module chirp_phase_fsm
    import chirp_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CPE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_long_len,
    input  logic [CNT_W-1:0] cfg_short_len,
    input  logic [CNT_W-1:0] cfg_listen_len,
    input  logic [CNT_W-1:0] cfg_guard_len,
    input  logic [CPE_W-1:0] cfg_cpe,
    output phase_e           state_q,
    output logic             chirp_done,
    output logic [CPE_W-1:0] cpe_q
);
    logic [CNT_W-1:0] long_q, short_q, listen_q, guard_q;
    logic [CNT_W-1:0] timer_q, cur_len, cur_lim;
    logic             phase_end, cycle_start;

    // Pick the captured length of the phase being timed.
    always_comb begin
        unique case (state_q)
            PH_LONG:   cur_len = long_q;
            PH_SHORT:  cur_len = short_q;
            PH_LISTEN: cur_len = listen_q;
            PH_GUARD:  cur_len = guard_q;
            default:   cur_len = '0;
        endcase
        cur_lim = (cur_len == '0) ? '0 : cur_len - 1'b1;
    end

    // Detect the last cycle of a phase and the start of a new cycle.
    always_comb begin
        phase_end   = (state_q != PH_IDLE) && (timer_q == cur_lim);
        chirp_done  = phase_end && (state_q == PH_GUARD);
        cycle_start = run && ((state_q == PH_IDLE) || chirp_done);
    end

    // Capture timing and chirp-count settings at each cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_q   <= '0;
            short_q  <= '0;
            listen_q <= '0;
            guard_q  <= '0;
            cpe_q    <= '0;
        end else if (cycle_start) begin
            long_q   <= cfg_long_len;
            short_q  <= cfg_short_len;
            listen_q <= cfg_listen_len;
            guard_q  <= cfg_guard_len;
            cpe_q    <= cfg_cpe;
        end
    end

    // Advance the phase register and the in-phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            timer_q <= '0;
        end else if (cycle_start) begin
            state_q <= PH_LONG;
            timer_q <= '0;
        end else if (phase_end) begin
            timer_q <= '0;
            unique case (state_q)
                PH_LONG:   state_q <= PH_SHORT;
                PH_SHORT:  state_q <= PH_LISTEN;
                PH_LISTEN: state_q <= PH_GUARD;
                default:   state_q <= PH_IDLE;
            endcase
        end else if (state_q != PH_IDLE) begin
            timer_q <= timer_q + 1'b1;
        end
    end

    AST_LONG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LONG) |=> (state_q == PH_LONG || state_q == PH_SHORT)); // R2
    AST_GUARD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_GUARD) |=> (state_q == PH_GUARD || state_q == PH_LONG || state_q == PH_IDLE)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && !run) |=> (state_q == PH_IDLE)); // R10
    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LONG || state_q == PH_SHORT || state_q == PH_LISTEN) |=> ($stable(long_q) && $stable(guard_q))); // R4
endmodule

// File: rtl/chirp_elev_counter.sv
// Module: chirp_elev_counter
// Counts finished chirps and pulses elev_step for one cycle when the
// captured chirps-per-elevation count is reached, then restarts.
// Assumes: chirp_done is a single-cycle strobe; a count of zero acts as one.
module chirp_elev_counter #(
    parameter int CPE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             chirp_done,
    input  logic [CPE_W-1:0] cpe_q,
    output logic             elev_step
);
    localparam int SUM_W = CPE_W + 1;

    logic [CPE_W-1:0] cnt_q;
    logic [SUM_W-1:0] cnt_next, target;

    // Form the incremented count and the effective target.
    always_comb begin
        cnt_next = {1'b0, cnt_q} + 1'b1;
        target   = (cpe_q == '0) ? SUM_W'(1) : {1'b0, cpe_q};
    end

    // Count chirps, emit the step pulse, clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            elev_step <= 1'b0;
        end else begin
            elev_step <= 1'b0;
            if (idle) begin
                cnt_q <= '0;
            end else if (chirp_done) begin
                if (cnt_next >= target) begin
                    cnt_q     <= '0;
                    elev_step <= 1'b1;
                end else begin
                    cnt_q <= cnt_next[CPE_W-1:0];
                end
            end
        end
    end

    AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        elev_step |=> !elev_step); // R8
    AST_STEP_AFTER_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(elev_step) |-> $past(chirp_done)); // R8
endmodule

// File: rtl/chirp_mixer_decode.sv
// Module: chirp_mixer_decode
// Decodes the phase register into the mixer enables and busy.
// Assumes: the input is a registered phase, so the outputs are glitch-free.
module chirp_mixer_decode
    import chirp_seq_pkg::*;
(
    input  phase_e state_q,
    output logic   tx_mix_en,
    output logic   rx_mix_en,
    output logic   busy
);
    // Transmit in both chirp phases, receive only while listening.
    always_comb begin
        tx_mix_en = (state_q == PH_LONG) || (state_q == PH_SHORT);
        rx_mix_en = (state_q == PH_LISTEN);
        busy      = (state_q != PH_IDLE);
    end
endmodule

// File: rtl/chirp_sequencer.sv
// Module: chirp_sequencer (top)
// Runs the long/short/listen/guard chirp cycle with runtime lengths,
// drives exclusive mixer enables and the elevation step pulse.
// Assumes: configuration inputs are synchronous to clk.
module chirp_sequencer
    import chirp_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CPE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_long_len,
    input  logic [CNT_W-1:0] cfg_short_len,
    input  logic [CNT_W-1:0] cfg_listen_len,
    input  logic [CNT_W-1:0] cfg_guard_len,
    input  logic [CPE_W-1:0] cfg_chirps_per_elev,
    output logic [2:0]       phase,
    output logic             tx_mix_en,
    output logic             rx_mix_en,
    output logic             busy,
    output logic             elev_step
);
    phase_e           state_q;
    logic             chirp_done;
    logic [CPE_W-1:0] cpe_q;

    chirp_phase_fsm #(.CNT_W(CNT_W), .CPE_W(CPE_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .run            (run),
        .cfg_long_len   (cfg_long_len),
        .cfg_short_len  (cfg_short_len),
        .cfg_listen_len (cfg_listen_len),
        .cfg_guard_len  (cfg_guard_len),
        .cfg_cpe        (cfg_chirps_per_elev),
        .state_q        (state_q),
        .chirp_done     (chirp_done),
        .cpe_q          (cpe_q)
    );

    chirp_elev_counter #(.CPE_W(CPE_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (state_q == PH_IDLE),
        .chirp_done (chirp_done),
        .cpe_q      (cpe_q),
        .elev_step  (elev_step)
    );

    chirp_mixer_decode u_dec (
        .state_q   (state_q),
        .tx_mix_en (tx_mix_en),
        .rx_mix_en (rx_mix_en),
        .busy      (busy)
    );

    assign phase = state_q;

    AST_MIX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_mix_en && rx_mix_en)); // R6
    AST_STEP_BUSY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        elev_step |-> (phase == 3'd1 || phase == 3'd0)); // R8
endmodule

// File: tb/chirp_sequencer_test.sv
module chirp_sequencer_test;
    localparam int CNT_W = 16;
    localparam int CPE_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [CNT_W-1:0] l_long = 0, l_short = 0, l_listen = 0, l_guard = 0;
    logic [CPE_W-1:0] cpe = 0;
    logic [2:0] phase;
    logic tx_mix_en, rx_mix_en, busy, elev_step;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit started = 1'b0;
    string ptag = "R1";

    // model state
    int m_state = 0, m_timer = 0, m_cnt = 0;
    int s_len[1:4];
    int s_cpe = 0;
    bit m_elev = 1'b0;

    always #5 clk = ~clk;

    chirp_sequencer #(.CNT_W(CNT_W), .CPE_W(CPE_W)) uut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cfg_long_len(l_long), .cfg_short_len(l_short),
        .cfg_listen_len(l_listen), .cfg_guard_len(l_guard),
        .cfg_chirps_per_elev(cpe),
        .phase(phase), .tx_mix_en(tx_mix_en), .rx_mix_en(rx_mix_en),
        .busy(busy), .elev_step(elev_step)
    );

    function automatic int eff_len(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model advanced at each rising edge.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_state = 0; m_timer = 0; m_cnt = 0; m_elev = 0; s_cpe = 0;
            for (int i = 1; i <= 4; i++) s_len[i] = 0;
        end else begin
            bit done;
            bit start;
            done = (m_state == 4) && (m_timer == eff_len(s_len[4]) - 1);
            m_elev = 0;
            if (m_state == 0) m_cnt = 0;
            else if (done) begin
                if (m_cnt + 1 >= eff_len(s_cpe)) begin m_cnt = 0; m_elev = 1; end
                else m_cnt++;
            end
            start = run && (m_state == 0 || done);
            if (start) begin
                s_len[1] = l_long; s_len[2] = l_short; s_len[3] = l_listen; s_len[4] = l_guard;
                s_cpe = cpe; m_state = 1; m_timer = 0;
            end else if (m_state != 0) begin
                if (m_timer == eff_len(s_len[m_state]) - 1) begin
                    m_timer = 0;
                    m_state = (m_state == 4) ? 0 : m_state + 1;
                end else m_timer++;
            end
        end
    end

    // Compare all outputs away from the rising edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(ptag, "phase", phase, m_state);
            chk("R5", "tx_mix_en", tx_mix_en, (m_state == 1 || m_state == 2));
            chk("R6", "rx_mix_en", rx_mix_en, (m_state == 3));
            chk("R6", "tx_and_rx", tx_mix_en & rx_mix_en, 0);
            chk("R7", "busy", busy, (m_state != 0));
            chk("R8", "elev_step", elev_step, m_elev);
        end
    end

    task automatic set_len(int a, int b, int c, int d, int n);
        l_long = a; l_short = b; l_listen = c; l_guard = d; cpe = n;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int steps;
        void'($urandom(32'd20260320));
        ptag = "R1";
        set_len(3, 2, 4, 2, 2);
        cyc(4);
        chk("R1", "phase_in_reset", phase, 0);
        rst_n = 1'b1;
        cyc(3);
        chk("R1", "idle_after_reset", phase, 0);

        ptag = "R10";
        run = 1'b1;
        cyc(1);
        chk("R10", "start_to_long", phase, 1);
        ptag = "R2";
        cyc(40);

        ptag = "R4";                    // change lengths mid-cycle
        set_len(1, 5, 1, 3, 1);
        cyc(30);

        ptag = "R3";                    // zero lengths
        set_len(0, 0, 0, 0, 0);
        cyc(20);
        chk("R3", "zero_len_advances", busy, 1);

        ptag = "R9";                    // stop mid-cycle
        set_len(4, 4, 4, 4, 3);
        cyc(10);
        run = 1'b0;
        cyc(25);
        chk("R9", "idle_after_stop", phase, 0);
        run = 1'b1;
        cyc(60);

        ptag = "R2";                    // random traffic
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 59) == 0) run = ~run;
            if ($urandom_range(0, 24) == 0) begin
                case ($urandom_range(0, 4))
                    0: l_long   = CNT_W'($urandom_range(0, 6));
                    1: l_short  = CNT_W'($urandom_range(0, 6));
                    2: l_listen = CNT_W'($urandom_range(0, 6));
                    3: l_guard  = CNT_W'($urandom_range(0, 6));
                    default: cpe = CPE_W'($urandom_range(0, 4));
                endcase
            end
            cyc(1);
        end
        run = 1'b0;
        steps = 0;
        while (phase != 0 && steps < 200) begin cyc(1); steps++; end
        chk("R9", "final_idle", phase, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule